// File: doc/BRIEF.md
# Rotating Circuit Schedule Sequencer

This block runs a circuit-switched crossbar on a fixed time-division schedule. A table holds up to `K_MAX` crossbar settings. Each setting names, for every input port, one output port and a flag that says whether that circuit exists. Once started, the sequencer visits the first `k` settings in strict round-robin order. Each setting is held for one slot of a programmable number of word cycles. Because every circuit comes around once per rotation, it receives one k-th of the link bandwidth. A typical slot length is ten 64-bit words, which is 80 bytes, and it can be matched to a known message size. Random all-to-all traffic among 32 ports would load 32 rotations; mesh-like traffic needs only four.

Circuits are set up ahead of demand and are never set up on request. Each source presents the destination of the message at its queue head. It is granted `send_ok` only while the current slot holds a valid circuit from that source to that destination. A source whose circuit is not up simply waits for the slot that carries it. Nothing preempts the rotation. The table can be changed only while the sequencer is halted. A start pulse begins the rotation at slot 0, and a single-cycle `slot_start` marks the first word cycle of every slot so the fabric can reconfigure.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: After reset the sequencer is halted: `running`, `slot_start` and every `send_ok` bit are 0, and `slot_idx` is 0.
- R2: A `start` pulse while halted, with `halt` low, makes `running` 1 with `slot_idx` 0 and `slot_start` 1 in the next cycle. The cycle count and active count are captured at that edge.
- R3: While running, each slot lasts exactly `slot_len` cycles. `slot_start` is 1 only in the first cycle of a slot, and `slot_idx` holds steady for the rest of the slot.
- R4: Slots advance by one in strict order, and the slot after `k-1` is slot 0.
- R5: `send_ok[p]` is 1 only when `running` is 1, `req_valid[p]` is 1, the current slot's entry for input p is valid, and `req_dest[p*PW +: PW]` equals that entry's destination. Otherwise it is 0.
- R6: A table write issued while running is ignored. It does not change the circuits seen in later slots.
- R7: `halt` stops the rotation. From the next cycle `running`, `slot_start` and `send_ok` are 0. `halt` wins over `start` when both are high in the same cycle.
- R8: `xbar_dest[p*PW +: PW]` and `xbar_en[p]` show the table entry for input p in the slot given by `slot_idx`.
- R9: A `start` pulse while running does not restart the rotation or change the slot timing.
- R10: An active count of 0 acts as 1, and one above `K_MAX` acts as `K_MAX`. A slot length of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe (honoured only while halted) |
| cfg_slot | input | KW | Table row to write |
| cfg_port | input | PW | Input port whose entry is written |
| cfg_dest | input | PW | Output port for that circuit |
| cfg_valid | input | 1 | Circuit exists for that input in that row |
| act_k | input | KCW | Number of rows in the rotation, captured on start |
| slot_len | input | LEN_W | Word cycles per slot, captured on start |
| start | input | 1 | Begin rotation at slot 0 |
| halt | input | 1 | Stop rotation |
| req_valid | input | N_PORTS | Source p has a message waiting |
| req_dest | input | N_PORTS*PW | Head-of-queue destination per source |
| running | output | 1 | Rotation active |
| slot_idx | output | KW | Current table row |
| slot_start | output | 1 | First cycle of a slot |
| xbar_dest | output | N_PORTS*PW | Current destination per input |
| xbar_en | output | N_PORTS | Current circuit-valid flag per input |
| send_ok | output | N_PORTS | Source may transmit this cycle |

## Verification
A control input sampled at one edge changes `running`, `slot_idx` and `slot_start` just after that edge, so each is due one cycle after the stimulus. `xbar_*` and `send_ok` follow the registered slot and the live request inputs within the same cycle. The bench drives inputs just after a falling edge. For each driven cycle it computes the state its own schedule model predicts after the next rising edge and queues it. A monitor pops and compares that entry on the following falling edge, so every comparison lands exactly one register stage after the stimulus that caused it.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/tdm_cfg_table.sv
module tdm_cfg_table #(
    parameter int N     = 4,
    parameter int K_MAX = 8,
    parameter int PW    = 2,
    parameter int KW    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [KW-1:0]   wr_slot,
    input  logic [PW-1:0]   wr_port,
    input  logic [PW-1:0]   wr_dest,
    input  logic            wr_valid,
    input  logic [KW-1:0]   rd_slot,
    output logic [N*PW-1:0] rd_dest,
    output logic [N-1:0]    rd_en
);

    logic [PW-1:0] dest_q [K_MAX][N];
    logic [PW-1:0] dest_d [K_MAX][N];
    logic [N-1:0]  en_q   [K_MAX];
    logic [N-1:0]  en_d   [K_MAX];

    // next-state: one entry may change per cycle
    always_comb begin
        dest_d = dest_q;
        en_d   = en_q;
        if (wr_en && (int'(wr_slot) < K_MAX) && (int'(wr_port) < N)) begin
            dest_d[wr_slot][wr_port] = wr_dest;
            en_d[wr_slot][wr_port]   = wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < K_MAX; s++) begin
                en_q[s] <= '0;
                for (int p = 0; p < N; p++) begin
                    dest_q[s][p] <= '0;
                end
            end
        end else begin
            dest_q <= dest_d;
            en_q   <= en_d;
        end
    end

    // read port: the whole row for the active slot
    for (genvar p = 0; p < N; p++) begin : g_rd
        assign rd_dest[p*PW +: PW] = dest_q[rd_slot][p];
        assign rd_en[p]            = en_q[rd_slot][p];
    end

endmodule

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
    import tdm_seq_pkg::*;
#(
    parameter int K_MAX = 8,
    parameter int KW    = 3,
    parameter int KCW   = 4,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             halt,
    input  logic [KCW-1:0]   act_k,
    input  logic [LEN_W-1:0] slot_len,
    output logic             running,
    output logic [KW-1:0]    slot_idx,
    output logic             slot_first
);

    typedef struct packed {
        seq_state_e       st;
        logic [KW-1:0]    slot;
        logic [LEN_W-1:0] word;
        logic [KCW-1:0]   k;
        logic [LEN_W-1:0] len;
    } timer_t;

    timer_t tm_q, tm_d;
    logic [KCW-1:0]   k_clamped;
    logic [LEN_W-1:0] len_clamped;
    logic             last_word;
    logic             last_slot;

    always_comb begin
        if (act_k == '0) begin
            k_clamped = KCW'(1);
        end else if (act_k > KCW'(K_MAX)) begin
            k_clamped = KCW'(K_MAX);
        end else begin
            k_clamped = act_k;
        end
        len_clamped = (slot_len == '0) ? LEN_W'(1) : slot_len;
        last_word   = (tm_q.word == tm_q.len - LEN_W'(1));
        last_slot   = ((KCW'(tm_q.slot) + KCW'(1)) >= tm_q.k);

        tm_d = tm_q;
        if (halt) begin
            tm_d.st = SEQ_IDLE;
        end else if (tm_q.st == SEQ_IDLE) begin
            if (start) begin
                tm_d.st   = SEQ_RUN;
                tm_d.slot = '0;
                tm_d.word = '0;
                tm_d.k    = k_clamped;
                tm_d.len  = len_clamped;
            end
        end else if (last_word) begin
            tm_d.word = '0;
            tm_d.slot = last_slot ? '0 : tm_q.slot + KW'(1);
        end else begin
            tm_d.word = tm_q.word + LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q <= '{st: SEQ_IDLE, slot: '0, word: '0, k: KCW'(1), len: LEN_W'(1)};
        end else begin
            tm_q <= tm_d;
        end
    end

    assign running    = (tm_q.st == SEQ_RUN);
    assign slot_idx   = tm_q.slot;
    assign slot_first = running && (tm_q.word == '0);

endmodule

// File: rtl/tdm_grant.sv
module tdm_grant #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic            running,
    input  logic [N-1:0]    req_valid,
    input  logic [N*PW-1:0] req_dest,
    input  logic [N*PW-1:0] cur_dest,
    input  logic [N-1:0]    cur_en,
    output logic [N-1:0]    send_ok
);

    for (genvar p = 0; p < N; p++) begin : g_port
        logic hit;
        assign hit        = (req_dest[p*PW +: PW] == cur_dest[p*PW +: PW]);
        assign send_ok[p] = running && req_valid[p] && cur_en[p] && hit;
    end

endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer #(
    parameter int N_PORTS = 4,
    parameter int K_MAX   = 8,
    parameter int LEN_W   = 8,
    localparam int PW     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int KW     = (K_MAX > 1) ? $clog2(K_MAX) : 1,
    localparam int KCW    = $clog2(K_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [KW-1:0]         cfg_slot,
    input  logic [PW-1:0]         cfg_port,
    input  logic [PW-1:0]         cfg_dest,
    input  logic                  cfg_valid,
    input  logic [KCW-1:0]        act_k,
    input  logic [LEN_W-1:0]      slot_len,
    input  logic                  start,
    input  logic                  halt,
    input  logic [N_PORTS-1:0]    req_valid,
    input  logic [N_PORTS*PW-1:0] req_dest,
    output logic                  running,
    output logic [KW-1:0]         slot_idx,
    output logic                  slot_start,
    output logic [N_PORTS*PW-1:0] xbar_dest,
    output logic [N_PORTS-1:0]    xbar_en,
    output logic [N_PORTS-1:0]    send_ok
);

    logic tbl_we;

    // the schedule is frozen while the rotation is live
    assign tbl_we = cfg_we && !running;

    tdm_cfg_table #(
        .N     (N_PORTS),
        .K_MAX (K_MAX),
        .PW    (PW),
        .KW    (KW)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_slot  (cfg_slot),
        .wr_port  (cfg_port),
        .wr_dest  (cfg_dest),
        .wr_valid (cfg_valid),
        .rd_slot  (slot_idx),
        .rd_dest  (xbar_dest),
        .rd_en    (xbar_en)
    );

    tdm_slot_timer #(
        .K_MAX (K_MAX),
        .KW    (KW),
        .KCW   (KCW),
        .LEN_W (LEN_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .halt       (halt),
        .act_k      (act_k),
        .slot_len   (slot_len),
        .running    (running),
        .slot_idx   (slot_idx),
        .slot_first (slot_start)
    );

    tdm_grant #(
        .N  (N_PORTS),
        .PW (PW)
    ) u_grant (
        .running   (running),
        .req_valid (req_valid),
        .req_dest  (req_dest),
        .cur_dest  (xbar_dest),
        .cur_en    (xbar_en),
        .send_ok   (send_ok)
    );

endmodule

// File: rtl/tdm_seq_checker.sv
module tdm_seq_checker #(
    parameter int N  = 4,
    parameter int KW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          halt,
    input logic          running,
    input logic          slot_start,
    input logic [KW-1:0] slot_idx,
    input logic [N-1:0]  send_ok
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!slot_start && send_ok == '0));

    p_start_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !halt && !running) |=> (running && slot_start && slot_idx == '0));

    p_hold_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !slot_start) |-> $stable(slot_idx));

    p_step_or_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && slot_start)
            |-> (slot_idx == $past(slot_idx) + KW'(1) || slot_idx == '0));

    p_halt_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && running) |=> (!running && send_ok == '0));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !halt && start) |=> running);

endmodule

bind tdm_slot_sequencer tdm_seq_checker #(
    .N  (N_PORTS),
    .KW (KW)
) u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .halt       (halt),
    .running    (running),
    .slot_start (slot_start),
    .slot_idx   (slot_idx),
    .send_ok    (send_ok)
);

// File: tb/tdm_slot_sequencer_test.sv
module tdm_slot_sequencer_test;

    localparam int N = 4;
    localparam int KM = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_slot = '0;
    logic [1:0] cfg_port = '0;
    logic [1:0] cfg_dest = '0;
    logic       cfg_valid = 1'b0;
    logic [3:0] act_k = '0;
    logic [7:0] slot_len = '0;
    logic       start = 1'b0;
    logic       halt = 1'b0;
    logic [3:0] req_valid = '0;
    logic [7:0] req_dest = '0;
    logic       running;
    logic [2:0] slot_idx;
    logic       slot_start;
    logic [7:0] xbar_dest;
    logic [3:0] xbar_en;
    logic [3:0] send_ok;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tdm_slot_sequencer #(.N_PORTS(N), .K_MAX(KM), .LEN_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_port(cfg_port), .cfg_dest(cfg_dest), .cfg_valid(cfg_valid),
        .act_k(act_k), .slot_len(slot_len), .start(start), .halt(halt),
        .req_valid(req_valid), .req_dest(req_dest), .running(running),
        .slot_idx(slot_idx), .slot_start(slot_start), .xbar_dest(xbar_dest),
        .xbar_en(xbar_en), .send_ok(send_ok)
    );

    typedef struct packed {
        logic       run;
        logic       ss;
        logic [2:0] slot;
        logic [3:0] ok;
        logic [7:0] xd;
        logic [3:0] xe;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    // reference schedule model
    logic [1:0] m_dest [KM][N];
    logic       m_val  [KM][N];
    bit         m_run = 1'b0;
    int         m_slot = 0;
    int         m_word = 0;
    int         m_k = 1;
    int         m_len = 1;

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, expv);
        end
    endtask

    // driver: apply current inputs to the model, queue expected result
    task automatic step(string tag);
        exp_t e;
        if (cfg_we && !m_run) begin
            m_dest[cfg_slot][cfg_port] = cfg_dest;
            m_val[cfg_slot][cfg_port]  = cfg_valid;
        end
        if (halt) begin
            m_run = 1'b0;
        end else if (!m_run) begin
            if (start) begin
                m_run  = 1'b1;
                m_slot = 0;
                m_word = 0;
                m_k    = (act_k == 0) ? 1 : ((int'(act_k) > KM) ? KM : int'(act_k));
                m_len  = (slot_len == 0) ? 1 : int'(slot_len);
            end
        end else if (m_word == m_len - 1) begin
            m_word = 0;
            m_slot = (m_slot + 1 >= m_k) ? 0 : m_slot + 1;
        end else begin
            m_word++;
        end
        e.run  = m_run;
        e.ss   = m_run && (m_word == 0);
        e.slot = 3'(m_slot);
        for (int p = 0; p < N; p++) begin
            e.xd[p*2 +: 2] = m_dest[m_slot][p];
            e.xe[p]        = m_val[m_slot][p];
            e.ok[p]        = m_run && req_valid[p] && m_val[m_slot][p]
                             && (req_dest[p*2 +: 2] == m_dest[m_slot][p]);
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    // monitor: compare on the falling edge after the driven cycle
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "running", int'(running), int'(e.run));
                check(t, "slot_start", int'(slot_start), int'(e.ss));
                check(t, "slot_idx", int'(slot_idx), int'(e.slot));
                check(t, "send_ok", int'(send_ok), int'(e.ok));
                check(t, "xbar_dest", int'(xbar_dest), int'(e.xd));
                check(t, "xbar_en", int'(xbar_en), int'(e.xe));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < KM; s++) begin
            for (int p = 0; p < N; p++) begin
                m_dest[s][p] = '0;
                m_val[s][p]  = 1'b0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle after reset
        check("R1", "running", int'(running), 0);
        check("R1", "send_ok", int'(send_ok), 0);
        req_valid = 4'hF;
        step("R1 idle");

        // load three rows; row 1 has no circuit for input 2
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < N; p++) begin
                cfg_we    = 1'b1;
                cfg_slot  = 3'(s);
                cfg_port  = 2'(p);
                cfg_dest  = 2'((p + s + 1) % 4);
                cfg_valid = !(s == 1 && p == 2);
                step("R8 load");
            end
        end
        cfg_we    = 1'b0;
        act_k     = 4'd3;
        slot_len  = 8'd3;
        // p0->1 (row0), p1->0 (row2), p2->0 (row1, invalid), p3->2 (row2)
        req_dest  = {2'd2, 2'd0, 2'd0, 2'd1};
        start     = 1'b1;
        step("R2 start");
        start     = 1'b0;
        repeat (14) step("R3 R4 R5 R8 rotation");

        // R6: write while running is dropped
        cfg_we = 1'b1; cfg_slot = 3'd0; cfg_port = 2'd0; cfg_dest = 2'd3; cfg_valid = 1'b1;
        step("R6 write");
        cfg_we = 1'b0;
        repeat (9) step("R6 after write");

        // R9: start while running
        start = 1'b1;
        step("R9 restart");
        start = 1'b0;
        repeat (4) step("R9 timing");

        // R5: second request pattern
        req_valid = 4'b0101;
        req_dest  = {2'd3, 2'd1, 2'd1, 2'd1};
        repeat (9) step("R5 mask");

        // R7: halt, including start in same cycle
        halt = 1'b1; start = 1'b1;
        step("R7 halt");
        halt = 1'b0; start = 1'b0;
        repeat (3) step("R7 idle");

        // R10: zero count and length act as one
        act_k = 4'd0; slot_len = 8'd0; start = 1'b1;
        step("R10 zero start");
        start = 1'b0;
        repeat (4) step("R10 zero");
        halt = 1'b1;
        step("R10 stop");
        halt = 1'b0;
        act_k = 4'd15; slot_len = 8'd1; start = 1'b1;
        step("R10 clamp start");
        start = 1'b0;
        repeat (10) step("R10 clamp");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule